// File: doc/BRIEF.md
# Rolled Double SHA-256 Share Search Core

This core runs the proof-of-work test for one candidate nonce. It applies the SHA-256 compression function twice, one round per clock. The first pass starts from a precomputed midstate and uses a 16-word block. That block is built from three header tail words, the nonce and fixed padding. The second pass starts from the standard initial hash values and hashes the 256-bit result of the first pass.

The last word of the final digest must be zero for a difficulty-1 share. The feed-forward constant for that word is fixed, so the core can decide the outcome one cycle early. The final h working word is a plain copy of the g word from the round before, so it is known before the last round finishes. If it cannot produce a zero, the core skips the feed-forward cycle and returns to idle at once. If it can, the core spends one extra cycle adding the feed-forward values and reports the share.

The parameter `EARLY_REJECT` selects between these two behaviours. When it is 0, every run takes the extra cycle and `digestOut` is always written. `SHARE_WORD` is the value that the last digest word must equal, and it defaults to 0.

Top module: `minerCore`

## Requirements
- R1: A `start` seen while idle captures `nonce` and all the other inputs. `busy` is high from the next cycle, and `nonceOut` shows the captured nonce.
- R2: The first-pass block has the three tail words in words 0 to 2 (tail word 0 in bits 95:64), the nonce in word 3 and 0x80000000 in word 4. Words 5 to 14 are zero and word 15 is 0x00000280. The first pass starts from the midstate, with word a in bits 255:224.
- R3: The second-pass block holds the first-pass digest in words 0 to 7 and 0x80000000 in word 8. Words 9 to 14 are zero and word 15 is 0x00000100. The pass starts from the standard initial hash values. On a full run `digestOut` holds the final digest, with H0 in bits 255:224.
- R4: Each round moves a to b, b to c, c to d, e to f, f to g and g to h. The new e is d+t1 and the new a is t1+t2, following the standard round functions. The schedule words come from a 16-word window.
- R5: With `EARLY_REJECT`=1, suppose the final h word does not equal SHARE_WORD minus 0x5be0cd19 (0xa41f32e7 by default). Then `done` rises 128 clock edges after the edge that took `start`.
- R6: On a full run (a qualifying h, or `EARLY_REJECT`=0), `done` rises 129 edges after the start edge.
- R7: `done` is a one-cycle pulse. `busy` is low in the cycle where `done` is high. `shareFound` is high only together with `done`.
- R8: `shareFound` is 1 exactly when the last digest word equals SHARE_WORD.
- R9: A `start` while busy is ignored. The run, its timing, its digest and `nonceOut` are unchanged, and `nonceOut` holds its value until the next accepted start.
- R10: While `rstN` is low, `busy`, `done` and `shareFound` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| midstate | input | 256 | Hash state after the first header block |
| tailWords | input | 96 | Three header tail words, word 0 on top |
| nonce | input | 32 | Candidate nonce |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| shareFound | output | 1 | Run found a difficulty-1 share |
| nonceOut | output | 32 | Nonce of the current or last run |
| digestOut | output | 256 | Final digest of the last full run |

## Verification
The start edge is taken as edge 0. A rejected run pulses `done` after edge 128 and a full run after edge 129. The bench drives two instances side by side, one with early reject and one without, from the same stimulus. It compares `busy`, `done` and `shareFound` of both against a per-edge expectation on every falling clock edge, so a result arriving one cycle early or late is caught in the exact cycle. The digest, the share flag and `nonceOut` are sampled only in the cycle in which each instance's `done` is expected.

// File: rtl/minerPkg.sv
package minerPkg;
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 8;
  localparam int BLOCK_WORDS = 16;
  localparam int TAIL_WORDS  = 3;
  localparam int ROUNDS      = 64;
  localparam int RND_W       = $clog2(ROUNDS);
  localparam int STATE_W     = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] wordT;

  localparam wordT PAD_WORD = 32'h8000_0000;
  localparam wordT LEN_HDR  = 32'd640;
  localparam wordT LEN_DIG  = 32'd256;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic step;
    logic finalAdd;
  } strobeT;

  localparam wordT IV_TABLE [NUM_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam wordT K_TABLE [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic wordT rotr(input wordT x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic wordT bigSig0(input wordT x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic wordT bigSig1(input wordT x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic wordT smallSig0(input wordT x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic wordT smallSig1(input wordT x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic wordT chooseFn(input wordT e, input wordT f, input wordT g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic wordT majFn(input wordT a, input wordT b, input wordT c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/minerCtrl.sv
module minerCtrl
  import minerPkg::*;
#(
  parameter bit EARLY_REJECT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             gMatch,
  input  logic             hMatch,
  output strobeT           strobe,
  output logic [RND_W-1:0] roundIdx,
  output logic             busy,
  output logic             done,
  output logic             shareFound
);
  typedef enum logic [1:0] {IDLE, PASS1, PASS2, FINISH} phaseT;

  phaseT            phase;
  logic [RND_W-1:0] rnd;
  logic             lastRound;
  logic             goFinish;

  assign lastRound = (rnd == RND_W'(ROUNDS - 1));

  generate
    if (EARLY_REJECT) begin : g_reject
      assign goFinish = gMatch;
    end else begin : g_full
      assign goFinish = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.loadFirst  = (phase == IDLE) && start;
    strobe.step       = (phase == PASS1) || (phase == PASS2);
    strobe.loadSecond = (phase == PASS1) && lastRound;
    strobe.finalAdd   = (phase == FINISH);
  end

  assign roundIdx = rnd;
  assign busy     = (phase != IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= IDLE;
      rnd        <= '0;
      done       <= 1'b0;
      shareFound <= 1'b0;
    end else begin
      done       <= 1'b0;
      shareFound <= 1'b0;
      unique case (phase)
        IDLE: begin
          if (start) begin
            phase <= PASS1;
            rnd   <= '0;
          end
        end
        PASS1: begin
          rnd <= rnd + 1'b1;
          if (lastRound) phase <= PASS2;
        end
        PASS2: begin
          rnd <= rnd + 1'b1;
          if (lastRound) begin
            if (goFinish) begin
              phase <= FINISH;
            end else begin
              phase <= IDLE;
              done  <= 1'b1;
            end
          end
        end
        FINISH: begin
          phase      <= IDLE;
          done       <= 1'b1;
          shareFound <= hMatch;
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/minerDatapath.sv
module minerDatapath
  import minerPkg::*;
#(
  parameter wordT CHECK_H = 32'ha41f32e7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [RND_W-1:0]   roundIdx,
  input  logic [STATE_W-1:0] midstate,
  input  logic [TAIL_WORDS*WORD_W-1:0] tailWords,
  input  wordT               nonce,
  output logic               gMatch,
  output logic               hMatch,
  output wordT               nonceOut,
  output logic [STATE_W-1:0] digestOut
);
  wordT st   [NUM_WORDS];
  wordT mid  [NUM_WORDS];
  wordT dig  [NUM_WORDS];
  wordT win  [BLOCK_WORDS];
  wordT nxt  [NUM_WORDS];
  wordT blk1 [BLOCK_WORDS];
  wordT blk2 [BLOCK_WORDS];
  wordT t1, t2, newW, nonceReg;

  always_comb begin
    t1 = st[7] + bigSig1(st[4]) + chooseFn(st[4], st[5], st[6]) + K_TABLE[roundIdx] + win[0];
    t2 = bigSig0(st[0]) + majFn(st[0], st[1], st[2]);
    nxt[0] = t1 + t2;
    nxt[1] = st[0];
    nxt[2] = st[1];
    nxt[3] = st[2];
    nxt[4] = st[3] + t1;
    nxt[5] = st[4];
    nxt[6] = st[5];
    nxt[7] = st[6];
    newW = smallSig1(win[14]) + win[9] + smallSig0(win[1]) + win[0];
  end

  always_comb begin
    for (int i = 0; i < BLOCK_WORDS; i++) begin
      blk1[i] = '0;
      blk2[i] = '0;
    end
    for (int i = 0; i < TAIL_WORDS; i++)
      blk1[i] = tailWords[WORD_W*(TAIL_WORDS-i)-1 -: WORD_W];
    blk1[TAIL_WORDS]     = nonce;
    blk1[TAIL_WORDS+1]   = PAD_WORD;
    blk1[BLOCK_WORDS-1]  = LEN_HDR;
    for (int i = 0; i < NUM_WORDS; i++)
      blk2[i] = nxt[i] + mid[i];
    blk2[NUM_WORDS]      = PAD_WORD;
    blk2[BLOCK_WORDS-1]  = LEN_DIG;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nonceReg <= '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
        st[i]  <= '0;
        mid[i] <= '0;
        dig[i] <= '0;
      end
      for (int i = 0; i < BLOCK_WORDS; i++) win[i] <= '0;
    end else begin
      if (strobe.loadFirst) begin
        nonceReg <= nonce;
        for (int i = 0; i < NUM_WORDS; i++) begin
          st[i]  <= midstate[WORD_W*(NUM_WORDS-i)-1 -: WORD_W];
          mid[i] <= midstate[WORD_W*(NUM_WORDS-i)-1 -: WORD_W];
        end
        for (int i = 0; i < BLOCK_WORDS; i++) win[i] <= blk1[i];
      end else if (strobe.loadSecond) begin
        for (int i = 0; i < NUM_WORDS; i++) st[i] <= IV_TABLE[i];
        for (int i = 0; i < BLOCK_WORDS; i++) win[i] <= blk2[i];
      end else if (strobe.step) begin
        for (int i = 0; i < NUM_WORDS; i++) st[i] <= nxt[i];
        for (int i = 0; i < BLOCK_WORDS-1; i++) win[i] <= win[i+1];
        win[BLOCK_WORDS-1] <= newW;
      end
      if (strobe.finalAdd) begin
        for (int i = 0; i < NUM_WORDS; i++) dig[i] <= st[i] + IV_TABLE[i];
      end
    end
  end

  assign gMatch   = (st[6] == CHECK_H);
  assign hMatch   = (st[7] == CHECK_H);
  assign nonceOut = nonceReg;

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++)
      digestOut[WORD_W*(NUM_WORDS-i)-1 -: WORD_W] = dig[i];
  end
endmodule

// File: rtl/minerCore.sv
module minerCore
  import minerPkg::*;
#(
  parameter bit          EARLY_REJECT = 1'b1,
  parameter logic [31:0] SHARE_WORD   = 32'h0000_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [255:0] midstate,
  input  logic [95:0]  tailWords,
  input  logic [31:0]  nonce,
  output logic         busy,
  output logic         done,
  output logic         shareFound,
  output logic [31:0]  nonceOut,
  output logic [255:0] digestOut
);
  localparam wordT CHECK_H = SHARE_WORD - IV_TABLE[NUM_WORDS-1];

  strobeT           strobe;
  logic [RND_W-1:0] roundIdx;
  logic             gMatch, hMatch;

  minerCtrl #(.EARLY_REJECT(EARLY_REJECT)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .gMatch(gMatch), .hMatch(hMatch),
    .strobe(strobe), .roundIdx(roundIdx), .busy(busy), .done(done),
    .shareFound(shareFound)
  );

  minerDatapath #(.CHECK_H(CHECK_H)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .roundIdx(roundIdx),
    .midstate(midstate), .tailWords(tailWords), .nonce(nonce),
    .gMatch(gMatch), .hMatch(hMatch), .nonceOut(nonceOut), .digestOut(digestOut)
  );
endmodule

// File: rtl/minerCoreChk.sv
module minerCoreChk #(
  parameter bit EARLY_REJECT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        shareFound,
  input logic [31:0] nonceOut
);
  localparam int ROUNDS = minerPkg::ROUNDS;
  logic [7:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else                busyCnt <= busyCnt + 1'b1;
  end

  a_r1_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r9_nonce_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(nonceOut));
  a_r7_share_with_done: assert property (@(posedge clk) disable iff (!rstN)
    shareFound |-> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r5_reject_latency: assert property (@(posedge clk) disable iff (!rstN)
    (done && !shareFound && EARLY_REJECT) |-> (busyCnt == 8'(2*ROUNDS)));
  a_r6_full_latency: assert property (@(posedge clk) disable iff (!rstN)
    (done && (shareFound || !EARLY_REJECT)) |-> (busyCnt == 8'(2*ROUNDS+1)));
endmodule

bind minerCore minerCoreChk #(.EARLY_REJECT(EARLY_REJECT)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .shareFound(shareFound), .nonceOut(nonceOut)
);

// File: tb/sim_minerCore.sv
module sim_minerCore;
  import minerPkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rstN, start;
  logic [255:0] midstate;
  logic [95:0]  tailWords;
  logic [31:0]  nonce;
  logic         busy0, done0, share0, busy1, done1, share1;
  logic [31:0]  nonceOut0, nonceOut1;
  logic [255:0] digest0, digest1;

  int checks = 0;
  int errors = 0;

  minerCore #(.EARLY_REJECT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .midstate(midstate), .tailWords(tailWords),
    .nonce(nonce), .busy(busy0), .done(done0), .shareFound(share0),
    .nonceOut(nonceOut0), .digestOut(digest0));

  minerCore #(.EARLY_REJECT(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .midstate(midstate), .tailWords(tailWords),
    .nonce(nonce), .busy(busy1), .done(done1), .shareFound(share1),
    .nonceOut(nonceOut1), .digestOut(digest1));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] hv, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] x1, x2;
    logic [255:0] res;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = hv[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + K_TABLE[t] + w[t];
      x2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + x1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = hv[255-32*i -: 32] + v[i];
    return res;
  endfunction

  function automatic logic [255:0] ivVec();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = IV_TABLE[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runJob(input logic [255:0] mid, input logic [95:0] tail,
                        input logic [31:0] n, input bit poke);
    logic [255:0] d1, d2;
    bit expShare;
    int doneK0;
    d1 = compress(mid, {tail, n, 32'h8000_0000, 320'b0, 32'h0000_0280});
    d2 = compress(ivVec(), {d1, 32'h8000_0000, 192'b0, 32'h0000_0100});
    expShare = (d2[31:0] == 32'h0);
    doneK0 = expShare ? 129 : 128;
    @(negedge clk);
    midstate = mid; tailWords = tail; nonce = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 132; k++) begin
      // R5 R6 R7: per-edge handshake of both instances
      check("R5 R6 R7 handshake",
            {250'b0, busy0, done0, share0, busy1, done1, share1},
            {250'b0, k < doneK0, k == doneK0, (k == doneK0) && expShare,
             k < 129, k == 129, (k == 129) && expShare});
      if (k == 0) check("R1 nonce capture", {224'b0, nonceOut0}, {224'b0, n});
      if (poke && k == 40) begin
        start = 1'b1; nonce = ~n; tailWords = ~tail; midstate = ~mid;
      end
      if (poke && k == 41) start = 1'b0;
      if (k == doneK0) begin
        check("R9 nonce held", {224'b0, nonceOut0}, {224'b0, n});
        check("R8 share early core", {255'b0, share0}, {255'b0, expShare});
      end
      if (k == 129) begin
        check("R2 R3 R4 digest", digest1, d2);
        check("R8 share full core", {255'b0, share1}, {255'b0, expShare});
        check("R1 nonce full core", {224'b0, nonceOut1}, {224'b0, n});
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b1; midstate = '0; tailWords = '0; nonce = '0;
    repeat (3) @(negedge clk);
    check("R10 reset", {250'b0, busy0, done0, share0, busy1, done1, share1}, 256'b0);
    start = 1'b0;
    rstN = 1'b1;
    // R4: reference round function self-test on a one-block message
    check("R4 reference",
          compress(ivVec(), {32'h6162_6380, 448'b0, 32'h0000_0018}),
          256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad);
    runJob(ivVec(), 96'h0123_4567_89ab_cdef_fedc_ba98, 32'h0000_0000, 1'b0);
    runJob({8{32'hffff_ffff}}, 96'h0, 32'hffff_ffff, 1'b0);
    runJob(256'h1f2e3d4c_5b6a7988_97a6b5c4_d3e2f101_deadbeef_0badf00d_12345678_9abcdef0,
           96'h4f3a_2b1c_0d9e_8f7a_6b5c_4d3e, 32'h1234_5678, 1'b1);
    runJob(256'h0, 96'hffff_ffff_0000_0000_aaaa_5555, 32'h8000_0001, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule